// File: doc/BRIEF.md
# Zero-Wait DRAM Controller with Hidden Refresh

This controller connects a processor bus that runs an asynchronous strobe/acknowledge handshake to one bank of page-mode DRAM. It runs on a clock at twice the processor rate, so each tick is half a processor clock and a minimum bus cycle of four processor clocks spans eight ticks. When the active-low address strobe is sampled low, the controller drives the row strobe at once. One tick later it switches the address multiplexer to the column and drives the column strobe. In that same tick it returns the active-low data acknowledge, which is early enough that the processor inserts no wait state.

A refresh interval timer raises a pending request. That request is normally served as a CAS-before-RAS refresh in the unused tail of the current bus cycle, straight after the access and its precharge, so the processor never sees it. If the bus has been quiet for a while, the refresh may also start from idle. A strobe that arrives while such a refresh or its precharge is still running is held off, and the access starts on a whole-processor-clock boundary. The acknowledge is then late by whole clocks rather than shortening precharge.

Top module: `zw_dram_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no strobe, ras_n, cas_n, we_n and dtack_n are high and mux_col is low.
- R2: On an idle controller, ras_n falls in the tick whose clock edge first samples as_n low, and dtack_n falls exactly one tick later (zero wait).
- R3: dram_addr carries addr[15:8] (the row) while mux_col is low and addr[7:0] (the column) while mux_col is high. mux_col rises and cas_n falls one tick after ras_n falls. dtack_n only falls while cas_n is low and mux_col is high.
- R4: For an access, ras_n stays low for exactly RAS_TICKS ticks. After any rise of ras_n, it stays high for at least PRE_TICKS ticks before falling again.
- R5: we_n is low only in the column-strobe ticks of a write access (rd_wr = 0). It stays high for reads and for refresh.
- R6: A refresh drops cas_n one tick before ras_n while ras_n is high. It then holds ras_n low for RAS_TICKS ticks, and both strobes rise together. About one refresh runs per REF_INTERVAL ticks.
- R7: Under back-to-back eight-tick bus cycles (strobe low six ticks, high two), every access is zero-wait and refreshes still keep pace with the interval timer.
- R8: When a strobe finds the controller busy, counting k = 0 at the first tick with as_n sampled low, the access ras_n fall happens at an even k, which is the first free even tick, and dtack_n falls at k + 1.
- R9: dtack_n is high in the tick after as_n is sampled high, and each strobe produces exactly one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-processor-clock tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Processor address strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Processor address, row in upper half |
| dtack_n | output | 1 | Data acknowledge to processor, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| mux_col | output | 1 | Address multiplexer select, 1 = column |
| we_n | output | 1 | DRAM write enable, active low |
| dram_addr | output | 8 | Multiplexed DRAM address |

## Verification
The hardest state to reach is a strobe that lands on a refresh started from idle. Tightly packed bus cycles never leave a long enough quiet gap for such a refresh, so it only begins after the strobe has been high for several ticks. The bench handles this directly: it parks the bus until it sees the column strobe fall with the row strobe still high, and then asserts the strobe on the very next tick. The expected acknowledge delay is derived from the refresh length, the precharge and the even-tick rule. Random cycles with gaps long enough to reach the quiet threshold then hit the same path at many different phases.

// File: rtl/zw_dram_pkg.sv
package zw_dram_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_ACC  = 2'd1,
    M_PRE  = 2'd2,
    M_REF  = 2'd3
  } mode_e;
endpackage

// File: rtl/zw_rst_sync.sv
module zw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/zw_ref_timer.sv
module zw_ref_timer #(
  parameter int REF_INTERVAL = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic ref_pend
);
  localparam int CNT_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(REF_INTERVAL - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    pend_d = pend_q;
    if (ref_done) pend_d = 1'b0;
    if (wrap)     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign ref_pend = pend_q;
endmodule

// File: rtl/zw_bus_seq.sv
module zw_bus_seq
  import zw_dram_pkg::*;
#(
  parameter int RAS_TICKS = 2,
  parameter int PRE_TICKS = 1,
  parameter int IDLE_GAP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic rd_wr,
  input  logic ref_pend,
  output logic ref_done,
  output logic ras_n,
  output logic cas_n,
  output logic mux_col,
  output logic we_n,
  output logic dtack_n
);
  localparam int STEP_MAX = (RAS_TICKS > PRE_TICKS) ? RAS_TICKS : PRE_TICKS;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int GAP_W    = $clog2(IDLE_GAP + 1);

  mode_e             mode_q, mode_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              served_q, served_d;
  logic              wr_q, wr_d;
  logic              ph_q, ph_d;
  logic              ack_q, ack_d;
  logic [GAP_W-1:0]  quiet_q, quiet_d;
  logic              quiet_ok, acc_req;
  logic              acc_on, acc_col, ref_on, ref_ras;

  assign quiet_ok = (quiet_q >= GAP_W'(IDLE_GAP));
  // An access may only begin on a whole processor clock boundary of the strobe.
  assign acc_req  = !as_n && !served_q && !ph_q;

  always_comb begin
    mode_d   = mode_q;
    step_d   = step_q;
    served_d = served_q;
    wr_d     = wr_q;
    ref_done = 1'b0;
    unique case (mode_q)
      M_IDLE: begin
        if (acc_req) begin
          mode_d   = M_ACC;
          step_d   = '0;
          served_d = 1'b1;
          wr_d     = !rd_wr;
        end else if (ref_pend && as_n && quiet_ok) begin
          mode_d = M_REF;
          step_d = '0;
        end
      end
      M_ACC: begin
        if (step_q == STEP_W'(RAS_TICKS - 1)) begin
          mode_d = M_PRE;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      M_PRE: begin
        if (step_q == STEP_W'(PRE_TICKS - 1)) begin
          step_d = '0;
          mode_d = ref_pend ? M_REF : M_IDLE;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      M_REF: begin
        if (step_q == STEP_W'(RAS_TICKS)) begin
          mode_d   = M_PRE;
          step_d   = '0;
          ref_done = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: mode_d = M_IDLE;
    endcase
    if (as_n) served_d = 1'b0;
    ph_d    = as_n ? 1'b0 : !ph_q;
    quiet_d = !as_n ? '0 : (quiet_ok ? quiet_q : quiet_q + 1'b1);
    if (as_n)                                 ack_d = 1'b0;
    else if (mode_q == M_ACC && step_q == '0) ack_d = 1'b1;
    else                                      ack_d = ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      step_q   <= '0;
      served_q <= 1'b0;
      wr_q     <= 1'b0;
      ph_q     <= 1'b0;
      ack_q    <= 1'b0;
      quiet_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      step_q   <= step_d;
      served_q <= served_d;
      wr_q     <= wr_d;
      ph_q     <= ph_d;
      ack_q    <= ack_d;
      quiet_q  <= quiet_d;
    end
  end

  assign acc_on  = (mode_q == M_ACC);
  assign acc_col = acc_on && (step_q != '0);
  assign ref_on  = (mode_q == M_REF);
  assign ref_ras = ref_on && (step_q != '0);

  assign ras_n   = !(acc_on || ref_ras);
  assign cas_n   = !(acc_col || ref_on);
  assign mux_col = acc_col;
  assign we_n    = !(acc_col && wr_q);
  assign dtack_n = !ack_q;
endmodule

// File: rtl/zw_addr_mux.sv
module zw_addr_mux #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic [ROW_W+COL_W-1:0]                       addr,
  input  logic                                         mux_col,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr
);
  localparam int AW   = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [MA_W-1:0] row_ext, col_ext;

  if (ROW_W == MA_W) begin : g_row_full
    assign row_ext = addr[AW-1:COL_W];
  end else begin : g_row_pad
    assign row_ext = {{(MA_W-ROW_W){1'b0}}, addr[AW-1:COL_W]};
  end

  if (COL_W == MA_W) begin : g_col_full
    assign col_ext = addr[COL_W-1:0];
  end else begin : g_col_pad
    assign col_ext = {{(MA_W-COL_W){1'b0}}, addr[COL_W-1:0]};
  end

  assign dram_addr = mux_col ? col_ext : row_ext;
endmodule

// File: rtl/zw_dram_ctrl.sv
module zw_dram_ctrl #(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 8,
  parameter int RAS_TICKS    = 2,
  parameter int PRE_TICKS    = 1,
  parameter int REF_INTERVAL = 24,
  parameter int IDLE_GAP     = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         as_n,
  input  logic                                         rd_wr,
  input  logic [ROW_W+COL_W-1:0]                       addr,
  output logic                                         dtack_n,
  output logic                                         ras_n,
  output logic                                         cas_n,
  output logic                                         mux_col,
  output logic                                         we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr
);
  logic rst_n_int;
  logic ref_pend, ref_done;

  zw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  zw_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ref_done (ref_done),
    .ref_pend (ref_pend)
  );

  zw_bus_seq #(
    .RAS_TICKS (RAS_TICKS),
    .PRE_TICKS (PRE_TICKS),
    .IDLE_GAP  (IDLE_GAP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .as_n     (as_n),
    .rd_wr    (rd_wr),
    .ref_pend (ref_pend),
    .ref_done (ref_done),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .mux_col  (mux_col),
    .we_n     (we_n),
    .dtack_n  (dtack_n)
  );

  zw_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .addr      (addr),
    .mux_col   (mux_col),
    .dram_addr (dram_addr)
  );
endmodule

// File: rtl/zw_dram_ctrl_chk.sv
module zw_dram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic dtack_n,
  input logic ras_n,
  input logic cas_n,
  input logic mux_col,
  input logic we_n
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_rst_quiet_r1: assert (ras_n && cas_n && we_n && dtack_n && !mux_col)
        else $error("reset state not quiet");
    end
  end

  p_ack_with_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> (!cas_n && mux_col));

  p_we_in_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cas_n && !ras_n && mux_col));

  p_cbr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> !ras_n);

  p_mux_in_ras_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mux_col |-> !ras_n);

  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> dtack_n);
endmodule

bind zw_dram_ctrl zw_dram_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .as_n    (as_n),
  .dtack_n (dtack_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .mux_col (mux_col),
  .we_n    (we_n)
);

// File: tb/zw_dram_ctrl_tb_top.sv
module zw_dram_ctrl_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int ROW_W        = 8;
  localparam int COL_W        = 8;
  localparam int RAS_TICKS    = 2;
  localparam int PRE_TICKS    = 1;
  localparam int REF_INTERVAL = 24;
  localparam int IDLE_GAP     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        as_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic [15:0] addr = 16'h0;
  logic        dtack_n, ras_n, cas_n, mux_col, we_n;
  logic [7:0]  dram_addr;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zw_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .RAS_TICKS(RAS_TICKS), .PRE_TICKS(PRE_TICKS),
    .REF_INTERVAL(REF_INTERVAL), .IDLE_GAP(IDLE_GAP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rd_wr(rd_wr), .addr(addr),
    .dtack_n(dtack_n), .ras_n(ras_n), .cas_n(cas_n), .mux_col(mux_col),
    .we_n(we_n), .dram_addr(dram_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected acknowledge tick when a strobe lands one tick into an idle refresh.
  function automatic int exp_busy_lat();
    int b = RAS_TICKS + PRE_TICKS;
    if (b % 2 != 0) b++;
    return b + 1;
  endfunction

  // ---------------- monitor (samples at falling edge) ----------------
  bit mon_en = 0;
  bit cur_wr = 0;
  int k = 0;
  bit ack_seen = 1;
  int acc_k = -1;
  int acc_cnt = 0;
  int last_lat = 0;
  int ras_low_run = 0;
  int ras_high_run = 100;
  int both_high_run = 0;
  bit cur_ref = 0;
  bit cbr_wait = 0;
  int ref_cnt = 0;
  logic p_ras = 1, p_cas = 1, p_as = 1, p_we = 1;

  always @(negedge clk) begin
    if (mon_en) begin
      if (!as_n) begin
        if (p_as) begin
          k = 0; ack_seen = 0; acc_k = -1; acc_cnt = 0;
        end else k = k + 1;
      end
      if (cbr_wait) begin
        chk(!ras_n, "R6 cbr ras after cas", ras_n, 0);
        cbr_wait = 0;
      end
      if (p_cas && !cas_n && ras_n) cbr_wait = 1;
      if (p_ras && !ras_n) begin
        chk(ras_high_run >= PRE_TICKS, "R4 precharge", ras_high_run, PRE_TICKS);
        cur_ref = !p_cas;
        if (cur_ref) ref_cnt++;
        else begin
          acc_cnt++;
          acc_k = k;
          chk(acc_cnt == 1, "R9 one access per strobe", acc_cnt, 1);
          chk(!as_n, "R9 access inside strobe", as_n, 0);
        end
        ras_low_run = 0;
      end
      if (!p_ras && ras_n) begin
        chk(ras_low_run == RAS_TICKS, cur_ref ? "R6 refresh ras width" : "R4 access ras width",
            ras_low_run, RAS_TICKS);
        chk(cas_n, "R6 strobes rise together", cas_n, 1);
        ras_high_run = 0;
      end
      if (!ras_n) ras_low_run++; else ras_high_run++;
      if (ras_n && cas_n) both_high_run++; else both_high_run = 0;
      if (!as_n && !dtack_n && !ack_seen) begin
        ack_seen = 1;
        last_lat = k;
        chk(acc_k >= 0 && k == acc_k + 1, "R8 ack one tick after ras", k, acc_k + 1);
        chk(acc_k % 2 == 0, "R8 access on even tick", acc_k, 0);
        chk(!cas_n && mux_col, "R3 ack with column", cas_n, 0);
      end
      if (as_n && !p_as) chk(dtack_n, "R9 ack released", dtack_n, 1);
      if (p_we && !we_n)
        chk(!cas_n && !ras_n && cur_wr && !cur_ref, "R5 we only in write column", we_n, 1);
    end
    p_ras = ras_n; p_cas = cas_n; p_as = as_n; p_we = we_n;
  end

  task automatic sync();
    @(negedge clk);
    #2;
  endtask

  task automatic bus_cycle(input logic [15:0] a, input bit rd, input int hold, input int gap);
    int n = 0;
    as_n = 1'b0; addr = a; rd_wr = rd; cur_wr = !rd;
    while (n < hold || !ack_seen) begin
      sync();
      n++;
    end
    as_n = 1'b1;
    for (int g = 0; g < gap; g++) sync();
  endtask

  task automatic wait_idle();
    while (both_high_run < PRE_TICKS + 1) sync();
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    int max_lat;
    int ref0;
    void'($urandom(32'h5EED_0042));
    #1 rst_n = 1'b0;
    repeat (3) sync();
    // R1: quiet outputs during reset
    chk(ras_n && cas_n && we_n && dtack_n && !mux_col, "R1 in reset",
        {ras_n, cas_n, we_n, dtack_n, mux_col}, 5'b11110);
    rst_n = 1'b1;
    repeat (3) sync();
    chk(ras_n && cas_n && we_n && dtack_n && !mux_col, "R1 after release",
        {ras_n, cas_n, we_n, dtack_n, mux_col}, 5'b11110);
    mon_en = 1;

    // R2/R3: directed read on an idle controller
    wait_idle();
    as_n = 1'b0; addr = 16'hA53C; rd_wr = 1'b1; cur_wr = 1'b0;
    sync();
    chk(!ras_n, "R2 ras at first sample", ras_n, 0);
    chk(cas_n && !mux_col, "R3 row phase", {cas_n, mux_col}, 2'b10);
    chk(dram_addr == 8'hA5, "R3 row address", dram_addr, 8'hA5);
    sync();
    chk(!dtack_n, "R2 zero-wait ack", dtack_n, 0);
    chk(!cas_n && mux_col, "R3 column phase", {cas_n, mux_col}, 2'b01);
    chk(dram_addr == 8'h3C, "R3 column address", dram_addr, 8'h3C);
    chk(we_n, "R5 read keeps we high", we_n, 1);
    sync();
    chk(ras_n && cas_n, "R4 access ends after RAS_TICKS", {ras_n, cas_n}, 2'b11);
    repeat (3) sync();
    as_n = 1'b1;
    sync();
    chk(dtack_n, "R9 ack high after strobe", dtack_n, 1);

    // R5: directed write
    wait_idle();
    as_n = 1'b0; addr = 16'h1277; rd_wr = 1'b0; cur_wr = 1'b1;
    sync();
    chk(we_n, "R5 we high in row tick", we_n, 1);
    sync();
    chk(!we_n && !dtack_n, "R5 write enable in column tick", we_n, 0);
    sync();
    chk(we_n, "R5 we released", we_n, 1);
    repeat (3) sync();
    as_n = 1'b1; rd_wr = 1'b1;
    repeat (2) sync();

    // R7/R6: back-to-back cycles keep zero wait with refresh hidden
    max_lat = 0;
    ref0 = ref_cnt;
    for (int c = 0; c < 60; c++) begin
      bus_cycle(16'($urandom), 1'($urandom), 6, 2);
      if (last_lat > max_lat) max_lat = last_lat;
    end
    chk(max_lat == 1, "R7 hidden refresh zero wait", max_lat, 1);
    chk(ref_cnt - ref0 >= (60*8)/REF_INTERVAL - 1 && ref_cnt - ref0 <= (60*8)/REF_INTERVAL + 1,
        "R6 refresh rate", ref_cnt - ref0, (60*8)/REF_INTERVAL);

    // R8: strobe arriving one tick into an idle refresh
    begin
      int guard = 0;
      while (!(!cas_n && ras_n) && guard < 400) begin
        sync();
        guard++;
      end
      chk(guard < 400, "R6 idle refresh issued", guard, 0);
    end
    bus_cycle(16'hBEEF, 1'b1, 6, 2);
    chk(last_lat == exp_busy_lat(), "R8 delayed ack latency", last_lat, exp_busy_lat());

    // random traffic, monitors check R3..R9 throughout
    for (int c = 0; c < 300; c++)
      bus_cycle(16'($urandom), 1'($urandom), 3 + int'($urandom % 6), 2 + int'($urandom % 8));
    chk(ref_cnt > 0, "R6 refreshes during random run", ref_cnt, 1);
    report();
  end
endmodule